// File: doc/BRIEF.md
# Aliased General-Purpose Register File

This block is a sixteen-entry, 64-bit general-purpose register file in which every entry can be accessed as a narrower view. A view can be a byte, a word, a doubleword or the full quadword. The first four entries also expose bits 15:8 as a separate high-byte view.

The file has two combinational read ports and one write port. Each port carries a register index, a size code, a high-byte select and an extension flag. A read returns the chosen field right-aligned, with zeros above it. A write changes only the chosen field, with one exception: a doubleword write in 64-bit mode clears bits 63:32.

A mode input selects between two modes:
- **Legacy mode** exposes only the first eight entries. Quadword access is not available.
- **64-bit mode** exposes all sixteen entries. Reaching entries 8 to 15, or using the quadword size, requires the extension flag.

Any access that breaks these rules is reported on that port's error output. An illegal read returns zero, and an illegal write is dropped. A read of the register being written in the same cycle sees the merged result of that write. Entry 4 serves as the stack pointer, but it is stored and accessed like every other entry.

Top module: `gpr_alias_file`

## Requirements
- R1: After reset every entry reads as zero.
- R2: Size code 0 is byte, 1 is word, 2 is doubleword and 3 is quadword. A legal read returns the low 8, 16, 32 or 64 bits of the entry, right-aligned and zero-padded.
- R3: A legal byte write (high-byte select 0) or word write replaces bits 7:0 or 15:0 and leaves all other bits of the entry unchanged.
- R4: With high-byte select 1 and size code 0 on entries 0 to 3, a read returns bits 15:8 in bits 7:0. A write replaces bits 15:8 and leaves all other bits unchanged.
- R5: A doubleword write replaces bits 31:0. In 64-bit mode it also clears bits 63:32. In legacy mode it leaves bits 63:32 unchanged.
- R6: In legacy mode (long_mode = 0), an access is illegal if it has an index of 8 or more, size code 3, or the extension flag set.
- R7: In 64-bit mode (long_mode = 1), an index of 8 or more, or size code 3, is legal only when the extension flag is 1.
- R8: A high-byte select is illegal if it comes with an index above 3, with the extension flag set, or with a size code other than 0.
- R9: An illegal write raises wr_err in the same cycle and leaves every entry unchanged.
- R10: An illegal read raises that port's error output and returns zero data.
- R11: A legal read of the entry being legally written in the same cycle returns the merged post-write value.
- R12: The two read ports are independent and may address different entries, sizes and views in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| long_mode | input | 1 | 1 = 64-bit mode, 0 = legacy mode |
| rd0_idx | input | 4 | Read port 0 entry index |
| rd0_size | input | 2 | Read port 0 size code |
| rd0_hi | input | 1 | Read port 0 high-byte select |
| rd0_ext | input | 1 | Read port 0 extension flag |
| rd0_data | output | 64 | Read port 0 field, right-aligned |
| rd0_err | output | 1 | Read port 0 illegal access |
| rd1_idx | input | 4 | Read port 1 entry index |
| rd1_size | input | 2 | Read port 1 size code |
| rd1_hi | input | 1 | Read port 1 high-byte select |
| rd1_ext | input | 1 | Read port 1 extension flag |
| rd1_data | output | 64 | Read port 1 field, right-aligned |
| rd1_err | output | 1 | Read port 1 illegal access |
| wr_en | input | 1 | Write request |
| wr_idx | input | 4 | Write entry index |
| wr_size | input | 2 | Write size code |
| wr_hi | input | 1 | Write high-byte select |
| wr_ext | input | 1 | Write extension flag |
| wr_data | input | 64 | Write data, right-aligned |
| wr_err | output | 1 | Illegal write, write dropped |

## Verification
The bench sweeps every combination of mode, index, size, high-byte select and extension flag, on both writes and reads. It compares each result with a reference model built from masks and shifts.

Each corner case catches a specific fault:
- A wrong merge would either clobber the bits around a narrow field or leave stale upper bits after a 64-bit-mode doubleword write.
- A legacy doubleword write that zero-extended would wrongly clear bits 63:32.
- A weak legality check would let a high-byte view reach entries 4 to 7, where it would alias the wrong bits, or would let an unflagged access reach the upper eight entries.
- Same-cycle write and read pairs expose a missing bypass as a stale read value.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_QUAD  = 2'd3
  } gpr_size_e;

  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 16;
  localparam int DWORD_W = 32;
endpackage

// File: rtl/gpr_access_check.sv
// Legality decode for one port (R6, R7, R8).
module gpr_access_check #(
  parameter int NREG        = 16,
  parameter int LEGACY_NREG = 8,
  parameter int HB_REGS     = 4,
  localparam int IDXW       = $clog2(NREG)
) (
  input  logic            long_mode,
  input  logic [IDXW-1:0] idx,
  input  logic [1:0]      size,
  input  logic            hi,
  input  logic            ext,
  output logic            ok
);
  import gpr_pkg::*;

  logic in_low_bank;
  logic hb_ok;
  logic base_ok;

  always_comb begin
    in_low_bank = (int'(idx) < LEGACY_NREG);
    // High-byte view: first entries only, byte size, no extension flag.
    hb_ok = (int'(idx) < HB_REGS) && (gpr_size_e'(size) == SZ_BYTE) && !ext;
    if (long_mode) begin
      base_ok = ext || (in_low_bank && (gpr_size_e'(size) != SZ_QUAD));
    end else begin
      base_ok = in_low_bank && (gpr_size_e'(size) != SZ_QUAD) && !ext;
    end
    ok = base_ok && (!hi || hb_ok);
  end
endmodule

// File: rtl/gpr_write_merge.sv
// Merges a right-aligned write field into the old entry value (R3, R4, R5).
module gpr_write_merge #(
  parameter int XLEN = 64
) (
  input  logic            long_mode,
  input  logic [1:0]      size,
  input  logic            hi,
  input  logic [XLEN-1:0] old_val,
  input  logic [XLEN-1:0] data,
  output logic [XLEN-1:0] new_val
);
  import gpr_pkg::*;

  localparam int UPPER_W = XLEN - DWORD_W;

  always_comb begin
    new_val = old_val;
    unique case (gpr_size_e'(size))
      SZ_BYTE: begin
        if (hi) new_val[WORD_W-1:BYTE_W] = data[BYTE_W-1:0];
        else    new_val[BYTE_W-1:0]      = data[BYTE_W-1:0];
      end
      SZ_WORD: new_val[WORD_W-1:0] = data[WORD_W-1:0];
      SZ_DWORD: begin
        new_val[DWORD_W-1:0] = data[DWORD_W-1:0];
        if (long_mode) new_val[XLEN-1:DWORD_W] = {UPPER_W{1'b0}};
      end
      SZ_QUAD: new_val = data;
      default: new_val = old_val;
    endcase
  end
endmodule

// File: rtl/gpr_read_extract.sv
// Selects the addressed view and right-aligns it (R2, R4, R10).
module gpr_read_extract #(
  parameter int XLEN = 64
) (
  input  logic            ok,
  input  logic [1:0]      size,
  input  logic            hi,
  input  logic [XLEN-1:0] val,
  output logic [XLEN-1:0] data
);
  import gpr_pkg::*;

  always_comb begin
    data = '0;
    if (ok) begin
      unique case (gpr_size_e'(size))
        SZ_BYTE: begin
          if (hi) data[BYTE_W-1:0] = val[WORD_W-1:BYTE_W];
          else    data[BYTE_W-1:0] = val[BYTE_W-1:0];
        end
        SZ_WORD:  data[WORD_W-1:0]  = val[WORD_W-1:0];
        SZ_DWORD: data[DWORD_W-1:0] = val[DWORD_W-1:0];
        SZ_QUAD:  data              = val;
        default:  data              = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpr_alias_file.sv
module gpr_alias_file #(
  parameter int NREG        = 16,
  parameter int LEGACY_NREG = 8,
  parameter int HB_REGS     = 4,
  parameter int XLEN        = 64,
  localparam int IDXW       = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            long_mode,
  input  logic [IDXW-1:0] rd0_idx,
  input  logic [1:0]      rd0_size,
  input  logic            rd0_hi,
  input  logic            rd0_ext,
  output logic [XLEN-1:0] rd0_data,
  output logic            rd0_err,
  input  logic [IDXW-1:0] rd1_idx,
  input  logic [1:0]      rd1_size,
  input  logic            rd1_hi,
  input  logic            rd1_ext,
  output logic [XLEN-1:0] rd1_data,
  output logic            rd1_err,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [1:0]      wr_size,
  input  logic            wr_hi,
  input  logic            wr_ext,
  input  logic [XLEN-1:0] wr_data,
  output logic            wr_err
);
  localparam int NRD = 2;

  logic [XLEN-1:0] regs_q [NREG];
  logic [XLEN-1:0] regs_d [NREG];
  logic [NREG-1:0] reg_en;

  logic            wr_ok;
  logic            wr_fire;
  logic [XLEN-1:0] wr_merged;

  // ---------------- write path ----------------
  gpr_access_check #(
    .NREG(NREG), .LEGACY_NREG(LEGACY_NREG), .HB_REGS(HB_REGS)
  ) u_wr_chk (
    .long_mode(long_mode), .idx(wr_idx), .size(wr_size),
    .hi(wr_hi), .ext(wr_ext), .ok(wr_ok)
  );

  gpr_write_merge #(.XLEN(XLEN)) u_merge (
    .long_mode(long_mode), .size(wr_size), .hi(wr_hi),
    .old_val(regs_q[wr_idx]), .data(wr_data), .new_val(wr_merged)
  );

  assign wr_fire = wr_en && wr_ok;
  assign wr_err  = wr_en && !wr_ok;

  // ---------------- storage ----------------
  for (genvar g = 0; g < NREG; g++) begin : g_entry
    always_comb begin
      reg_en[g] = wr_fire && (int'(wr_idx) == g);
      regs_d[g] = wr_merged;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs_q[g] <= '0;
      end else if (reg_en[g]) begin
        regs_q[g] <= regs_d[g];
      end
    end
  end

  // ---------------- read ports ----------------
  logic [IDXW-1:0] rp_idx  [NRD];
  logic [1:0]      rp_size [NRD];
  logic            rp_hi   [NRD];
  logic            rp_ext  [NRD];
  logic            rp_ok   [NRD];
  logic [XLEN-1:0] rp_src  [NRD];
  logic [XLEN-1:0] rp_out  [NRD];

  always_comb begin
    rp_idx[0] = rd0_idx;  rp_size[0] = rd0_size;
    rp_hi[0]  = rd0_hi;   rp_ext[0]  = rd0_ext;
    rp_idx[1] = rd1_idx;  rp_size[1] = rd1_size;
    rp_hi[1]  = rd1_hi;   rp_ext[1]  = rd1_ext;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rport
    gpr_access_check #(
      .NREG(NREG), .LEGACY_NREG(LEGACY_NREG), .HB_REGS(HB_REGS)
    ) u_chk (
      .long_mode(long_mode), .idx(rp_idx[p]), .size(rp_size[p]),
      .hi(rp_hi[p]), .ext(rp_ext[p]), .ok(rp_ok[p])
    );

    // Write-first bypass of the merged value.
    always_comb begin
      if (wr_fire && (wr_idx == rp_idx[p])) rp_src[p] = wr_merged;
      else                                  rp_src[p] = regs_q[rp_idx[p]];
    end

    gpr_read_extract #(.XLEN(XLEN)) u_ext (
      .ok(rp_ok[p]), .size(rp_size[p]), .hi(rp_hi[p]),
      .val(rp_src[p]), .data(rp_out[p])
    );
  end

  assign rd0_data = rp_out[0];
  assign rd0_err  = !rp_ok[0];
  assign rd1_data = rp_out[1];
  assign rd1_err  = !rp_ok[1];
endmodule

// File: rtl/gpr_alias_file_chk.sv
module gpr_alias_file_chk #(
  parameter int XLEN = 64,
  parameter int IDXW = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            long_mode,
  input logic [IDXW-1:0] rd0_idx,
  input logic [1:0]      rd0_size,
  input logic            rd0_hi,
  input logic            rd0_ext,
  input logic [XLEN-1:0] rd0_data,
  input logic            rd0_err,
  input logic            wr_en,
  input logic [IDXW-1:0] wr_idx,
  input logic [1:0]      wr_size,
  input logic            wr_hi,
  input logic            wr_ext,
  input logic [XLEN-1:0] wr_data,
  input logic            wr_err
);
  p_err_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd0_err |-> (rd0_data == '0));

  p_legacy_upper_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!long_mode && rd0_idx[IDXW-1]) |-> rd0_err);

  p_hibyte_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_hi && (wr_ext || (wr_idx > 3))) |-> wr_err);

  p_byte_pad_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd0_err && (rd0_size == 2'd0)) |-> (rd0_data[XLEN-1:8] == '0));

  p_noext_quad_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (long_mode && !rd0_ext && (rd0_size == 2'd3)) |-> rd0_err);

  p_bypass_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_err && (wr_size == 2'd3) && !rd0_err &&
     (rd0_size == 2'd3) && (rd0_idx == wr_idx)) |-> (rd0_data == wr_data));

  p_quad_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_err && (wr_size == 2'd3)) |=>
      ((rd0_idx == $past(wr_idx)) && (rd0_size == 2'd3) && !rd0_err &&
       !(wr_en && !wr_err && (wr_idx == rd0_idx))) |-> (rd0_data == $past(wr_data)));
endmodule

bind gpr_alias_file gpr_alias_file_chk #(.XLEN(XLEN), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .long_mode(long_mode),
  .rd0_idx(rd0_idx), .rd0_size(rd0_size), .rd0_hi(rd0_hi), .rd0_ext(rd0_ext),
  .rd0_data(rd0_data), .rd0_err(rd0_err),
  .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size), .wr_hi(wr_hi),
  .wr_ext(wr_ext), .wr_data(wr_data), .wr_err(wr_err)
);

// File: tb/sim_gpr_alias_file.sv
`timescale 1ns/1ps
module sim_gpr_alias_file;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        long_mode;
  logic [3:0]  rd0_idx, rd1_idx, wr_idx;
  logic [1:0]  rd0_size, rd1_size, wr_size;
  logic        rd0_hi, rd1_hi, wr_hi;
  logic        rd0_ext, rd1_ext, wr_ext;
  logic [63:0] rd0_data, rd1_data, wr_data;
  logic        rd0_err, rd1_err, wr_en, wr_err;

  int total = 0;
  int bad = 0;
  logic [63:0] model [16];

  always #10 clk = ~clk;

  gpr_alias_file u0 (
    .clk(clk), .rst_n(rst_n), .long_mode(long_mode),
    .rd0_idx(rd0_idx), .rd0_size(rd0_size), .rd0_hi(rd0_hi), .rd0_ext(rd0_ext),
    .rd0_data(rd0_data), .rd0_err(rd0_err),
    .rd1_idx(rd1_idx), .rd1_size(rd1_size), .rd1_hi(rd1_hi), .rd1_ext(rd1_ext),
    .rd1_data(rd1_data), .rd1_err(rd1_err),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_size(wr_size), .wr_hi(wr_hi),
    .wr_ext(wr_ext), .wr_data(wr_data), .wr_err(wr_err)
  );

  // Legality from R6, R7, R8.
  function automatic bit legal(bit lm, int idx, int sz, bit hi, bit ext);
    bit base;
    if (lm) base = ext || (idx < 8 && sz != 3);
    else    base = (idx < 8) && (sz != 3) && !ext;
    if (hi) return base && idx < 4 && sz == 0 && !ext;
    return base;
  endfunction

  function automatic logic [63:0] szmask(int sz);
    case (sz)
      0: return 64'hFF;
      1: return 64'hFFFF;
      2: return 64'hFFFF_FFFF;
      default: return '1;
    endcase
  endfunction

  // Merge from R3, R4, R5.
  function automatic logic [63:0] merge(bit lm, int sz, bit hi, logic [63:0] old_v, logic [63:0] d);
    logic [63:0] m;
    if (hi) begin
      m = 64'hFF00;
      return (old_v & ~m) | ((d & 64'hFF) << 8);
    end
    m = szmask(sz);
    if (sz == 2 && lm) return d & m;
    return (old_v & ~m) | (d & m);
  endfunction

  // View from R2, R4, R10.
  function automatic logic [63:0] view(bit ok, int sz, bit hi, logic [63:0] v);
    if (!ok) return '0;
    if (hi)  return (v >> 8) & 64'hFF;
    return v & szmask(sz);
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(int idx, int sz, bit hi, bit ext, logic [63:0] d, string req);
    bit ok;
    ok = legal(long_mode, idx, sz, hi, ext);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'(idx); wr_size = 2'(sz); wr_hi = hi; wr_ext = ext; wr_data = d;
    #2;
    chk({req, " R9 wr_err"}, {63'd0, wr_err}, {63'd0, !ok});
    @(posedge clk);
    if (ok) model[idx] = merge(long_mode, sz, hi, model[idx], d);
    #1 wr_en = 1'b0;
  endtask

  task automatic do_read(int i0, int s0, bit h0, bit e0, int i1, int s1, bit h1, bit e1, string req);
    bit ok0, ok1;
    ok0 = legal(long_mode, i0, s0, h0, e0);
    ok1 = legal(long_mode, i1, s1, h1, e1);
    @(negedge clk);
    rd0_idx = 4'(i0); rd0_size = 2'(s0); rd0_hi = h0; rd0_ext = e0;
    rd1_idx = 4'(i1); rd1_size = 2'(s1); rd1_hi = h1; rd1_ext = e1;
    #2;
    chk({req, " R12 port0 data"}, rd0_data, view(ok0, s0, h0, model[i0]));
    chk({req, " R10 port0 err"}, {63'd0, rd0_err}, {63'd0, !ok0});
    chk({req, " R12 port1 data"}, rd1_data, view(ok1, s1, h1, model[i1]));
    chk({req, " R10 port1 err"}, {63'd0, rd1_err}, {63'd0, !ok1});
  endtask

  // Same-cycle write and read of one entry (R11).
  task automatic bypass(int idx, int wsz, bit whi, int rsz, bit rhi, logic [63:0] d);
    bit wok, rok;
    logic [63:0] nv;
    wok = legal(long_mode, idx, wsz, whi, 1'b0);
    rok = legal(long_mode, idx, rsz, rhi, 1'b0);
    nv = wok ? merge(long_mode, wsz, whi, model[idx], d) : model[idx];
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 4'(idx); wr_size = 2'(wsz); wr_hi = whi; wr_ext = 1'b0; wr_data = d;
    rd0_idx = 4'(idx); rd0_size = 2'(rsz); rd0_hi = rhi; rd0_ext = 1'b0;
    #2;
    chk("R11 bypass data", rd0_data, view(rok, rsz, rhi, nv));
    @(posedge clk);
    model[idx] = nv;
    #1 wr_en = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; long_mode = 1'b1; wr_en = 1'b0;
    wr_idx = '0; wr_size = '0; wr_hi = 1'b0; wr_ext = 1'b0; wr_data = '0;
    rd0_idx = '0; rd0_size = '0; rd0_hi = 1'b0; rd0_ext = 1'b0;
    rd1_idx = '0; rd1_size = '0; rd1_hi = 1'b0; rd1_ext = 1'b0;
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    #3 rst_n = 1'b1;

    // R1: all entries zero after reset.
    for (int i = 0; i < 16; i++) do_read(i, 3, 0, 1, 15 - i, 3, 0, 1, "R1 reset");

    // Fill every entry with a distinct quadword.
    for (int i = 0; i < 16; i++)
      do_write(i, 3, 0, 1, 64'h0F1E_2D3C_4B5A_6978 ^ (64'(i) * 64'h1111_1111_1111_1111), "R2 fill");
    for (int i = 0; i < 16; i++) do_read(i, 3, 0, 1, i, 2, 0, 0, "R2 fill read");

    // Write sweep in both modes; each write followed by a full readback.
    for (int lm = 1; lm >= 0; lm--) begin
      long_mode = lm[0];
      for (int i = 0; i < 16; i++)
        for (int s = 0; s < 4; s++)
          for (int h = 0; h < 2; h++)
            for (int e = 0; e < 2; e++) begin
              do_write(i, s, h[0], e[0],
                       64'hA5C3_9617_E24B_D80F ^ {16'(i), 16'(s), 16'(h + 2 * e), 16'(lm)},
                       "R3/R4/R5/R6/R7/R8");
              long_mode = 1'b1;
              do_read(i, 3, 0, 1, i, 0, 1, 0, "R3/R4/R5 readback");
              long_mode = lm[0];
            end
    end

    // Read legality sweep in both modes.
    for (int lm = 0; lm < 2; lm++) begin
      long_mode = lm[0];
      for (int i = 0; i < 16; i++)
        for (int s = 0; s < 4; s++)
          for (int h = 0; h < 2; h++)
            for (int e = 0; e < 2; e++)
              do_read(i, s, h[0], e[0], 15 - i, 3 - s, e[0], h[0], "R2/R4/R6/R7/R8/R10");
    end

    // Bypass cases.
    long_mode = 1'b1;
    bypass(2, 0, 1, 1, 0, 64'h1234_5678_9ABC_DEF0);
    bypass(5, 2, 0, 2, 0, 64'hFFFF_FFFF_8765_4321);
    bypass(0, 1, 0, 0, 1, 64'h0000_0000_0000_BEEF);
    bypass(6, 0, 1, 0, 0, 64'h55);
    long_mode = 1'b0;
    bypass(3, 2, 0, 1, 0, 64'hDEAD_BEEF_CAFE_F00D);
    long_mode = 1'b1;
    do_read(3, 3, 0, 1, 5, 3, 0, 1, "R5/R11 after bypass");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule